// File: doc/BRIEF.md
# Serial Flash Transaction Sequencer

This block carries out one serial flash transaction at a time. Software sets the transaction up in a small register file and then starts it. A transaction runs through up to five phases, always in the same fixed order: an opcode byte, an address, a run of idle (dummy) clocks, outgoing data and incoming data. Each phase has its own enable and its own lane width of one, two or four lanes. The block drives the chip select, the serial clock and four lane outputs with per-lane output enables. Incoming lane values are sampled on the rising serial clock edge.

Outgoing data comes from a byte-wide transfer buffer and incoming data is written back into it. Both directions start at buffer index zero. Software polls a finish bit to learn that the transaction has ended. A separate updated bit tells it that received bytes are ready in the buffer. The serial clock runs at half the system clock: each serial clock is one system cycle low followed by one system cycle high.

Top module: `sflash_seq`

## Requirements
- R1: After reset every register reads zero, chip select is high, the serial clock is low and no lane is enabled. Registers 1 to 4 read back what was written. Register 0 reads busy at bit 31, finish at bit 30 and updated at bit 0.
- R2: Writing register 0 with bit 31 set while idle starts a transaction. From the next cycle busy reads 1 and finish and updated read 0, and chip select is low.
- R3: Enabled phases run in the order opcode, address, dummy, transmit, receive, and a disabled phase takes no clocks. A dummy phase with a zero count, or a data phase with a zero byte count, is skipped.
- R4: The opcode phase is enabled by register 1 bit 30, with width at bits 29:28 and opcode at bits 27:20. It sends 8 bits, most significant first. Width code 0 uses lane 0 only. Code 1 sends two bits per clock, the higher one on lane 1. Code 2 sends four bits per clock, the highest on lane 3.
- R5: The address phase is enabled by register 1 bit 19, with width at bits 18:17 and byte count minus one at bits 16:15. It sends the low bytes of register 4, most significant of those bytes first.
- R6: The dummy phase is enabled by register 2 bit 31 and lasts the number of serial clocks at bits 28:23. During it all lane output enables are low.
- R7: The transmit phase is enabled by register 1 bit 14, with width at bits 11:10 and byte count at bits 9:0. It sends buffer bytes from index 0 upward. A count above 512 sends 512 bytes.
- R8: The receive phase is enabled by register 3 bit 31, with width at bits 28:27 and byte count at bits 25:16, limited to 512. In single width it samples lane 1. In dual width lane 1 carries the higher bit, and in quad width lane 3 carries the highest. Received byte k is written to buffer index k.
- R9: The serial clock idles low and each serial clock is one system cycle low then one high. Outputs change only as the clock falls. Chip select stays low for 2N+1 system cycles for a transaction of N serial clocks.
- R10: When the transaction ends, busy clears and finish sets. Updated sets only if a receive phase ran. A transaction with no enabled phase still completes.
- R11: A start written while busy has no effect on the running transaction.
- R12: Only the lanes of the current width are enabled during opcode, address and transmit phases. No lane is enabled during dummy or receive phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register index: 0 control/status, 1 opcode/address/transmit, 2 dummy, 3 receive, 4 address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| sf_cs_n | output | 1 | Chip select, active low |
| sf_sclk | output | 1 | Serial clock |
| sf_dout | output | 4 | Lane output values |
| sf_oe | output | 4 | Lane output enables |
| sf_din | input | 4 | Lane input values |
| buf_addr | output | BUF_AW | Transfer buffer byte index |
| buf_re | output | 1 | Buffer read strobe, data taken the same cycle |
| buf_we | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write byte |
| buf_rdata | input | 8 | Buffer read byte, combinational from buf_addr |

## Verification
The bench goes after the byte count clamp: a count of 600 must stop after 512 bytes. A design that missed the clamp would emit extra serial clocks, and the empty scoreboard would flag them. It skips dummy and data phases whose count is zero; a sequencer that entered them anyway would stall or emit stray clocks. It checks the buffer index restart when a transmit phase is followed by a receive phase, where a missing restart would leave received bytes at the wrong indices. It also checks a transaction with no phases at all, which must still raise finish after a single chip select cycle. A start repeated mid-transaction must not restart the sequence, which would duplicate opcode clocks. Lane mapping and the selection of address bytes are checked clock by clock against an expected lane queue.

// File: rtl/sflash_seq.sv
module sflash_seq #(
  parameter int BUF_AW    = 9,
  parameter int MAX_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              sf_cs_n,
  output logic              sf_sclk,
  output logic [3:0]        sf_dout,
  output logic [3:0]        sf_oe,
  input  logic [3:0]        sf_din,
  output logic [BUF_AW-1:0] buf_addr,
  output logic              buf_re,
  output logic              buf_we,
  output logic [7:0]        buf_wdata,
  input  logic [7:0]        buf_rdata
);
  localparam int LW = 10;
  localparam logic [LW-1:0] MAXN = LW'(MAX_BYTES);

  typedef enum logic [2:0] {P_IDLE, P_CMD, P_ADDR, P_DUMMY, P_TX, P_RX, P_TAIL} ph_t;

  logic [31:0] c1, c2, c3, adr;
  logic        busy, fin, upd, half;
  ph_t         ph, nxt, tgt;
  logic [31:0] sh, ld_sh;
  logic [7:0]  rsh;
  logic [5:0]  cnt, ld_cnt;
  logic [1:0]  md, ld_m;
  logic [LW-1:0] bidx;
  logic [5:1]  en;

  function automatic logic [1:0] eff(input logic [1:0] m);
    return (m == 2'd3) ? 2'd2 : m;
  endfunction

  wire [LW-1:0] tx_len = (c1[9:0] > MAXN) ? MAXN : c1[9:0];
  wire [LW-1:0] rx_len = (c3[25:16] > MAXN) ? MAXN : c3[25:16];

  assign en = {c3[31] && rx_len != '0, c1[14] && tx_len != '0,
               c2[31] && c2[28:23] != 6'd0, c1[19], c1[30]};

  always_comb begin
    nxt = P_TAIL;
    for (int i = 5; i >= 1; i--)
      if (en[i] && i > int'(ph)) nxt = ph_t'(i[2:0]);
  end

  wire in_ph    = (ph == P_CMD) || (ph == P_ADDR) || (ph == P_DUMMY) || (ph == P_TX) || (ph == P_RX);
  wire start    = reg_we && reg_sel == 3'd0 && reg_wdata[31] && !busy;
  wire unit_end = in_ph && half && cnt == 6'd1;
  wire more_tx  = ph == P_TX && bidx < tx_len;
  wire more_rx  = ph == P_RX && (bidx + LW'(1)) < rx_len;
  wire step     = start || unit_end;

  assign tgt = more_tx ? P_TX : more_rx ? P_RX : nxt;

  always_comb begin
    ld_m   = 2'd0;
    ld_sh  = '0;
    ld_cnt = 6'd0;
    case (tgt)
      P_CMD: begin
        ld_m   = eff(c1[29:28]);
        ld_sh  = {c1[27:20], 24'h0};
        ld_cnt = 6'd8 >> ld_m;
      end
      P_ADDR: begin
        ld_m   = eff(c1[18:17]);
        ld_sh  = adr << {~c1[16:15], 3'b000};
        ld_cnt = ({1'b0, c1[16:15], 3'b000} + 6'd8) >> ld_m;
      end
      P_DUMMY: ld_cnt = c2[28:23];
      P_TX: begin
        ld_m   = eff(c1[11:10]);
        ld_sh  = {buf_rdata, 24'h0};
        ld_cnt = 6'd8 >> ld_m;
      end
      P_RX: begin
        ld_m   = eff(c3[28:27]);
        ld_cnt = 6'd8 >> ld_m;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1 <= '0; c2 <= '0; c3 <= '0; adr <= '0;
      busy <= 1'b0; fin <= 1'b0; upd <= 1'b0; half <= 1'b0;
      ph <= P_IDLE; sh <= '0; rsh <= '0; cnt <= '0; md <= '0; bidx <= '0;
      sf_cs_n <= 1'b1;
    end else begin
      if (reg_we)
        case (reg_sel)
          3'd1: c1  <= reg_wdata;
          3'd2: c2  <= reg_wdata;
          3'd3: c3  <= reg_wdata;
          3'd4: adr <= reg_wdata;
          default: ;
        endcase
      if (step) begin
        ph   <= tgt;
        sh   <= ld_sh;
        cnt  <= ld_cnt;
        md   <= ld_m;
        half <= 1'b0;
        case (tgt)
          P_TX:    bidx <= bidx + LW'(1);
          P_RX:    bidx <= (ph == P_RX) ? bidx + LW'(1) : '0;
          P_TAIL:  bidx <= '0;
          default: ;
        endcase
        if (start) begin
          busy <= 1'b1; fin <= 1'b0; upd <= 1'b0; sf_cs_n <= 1'b0;
        end
      end else if (ph == P_TAIL) begin
        ph <= P_IDLE; sf_cs_n <= 1'b1; busy <= 1'b0; fin <= 1'b1; upd <= en[5];
      end else if (in_ph) begin
        half <= ~half;
        if (!half) begin
          if (ph == P_RX)
            case (md)
              2'd0:    rsh <= {rsh[6:0], sf_din[1]};
              2'd1:    rsh <= {rsh[5:0], sf_din[1:0]};
              default: rsh <= {rsh[3:0], sf_din};
            endcase
        end else begin
          cnt <= cnt - 6'd1;
          sh  <= sh << (6'd1 << md);
        end
      end
    end
  end

  wire drive = (ph == P_CMD) || (ph == P_ADDR) || (ph == P_TX);
  assign sf_oe   = !drive ? 4'b0000 : (md == 2'd0) ? 4'b0001 : (md == 2'd1) ? 4'b0011 : 4'b1111;
  assign sf_dout = ((md == 2'd0) ? {3'b000, sh[31]} : (md == 2'd1) ? {2'b00, sh[31:30]} : sh[31:28]) & sf_oe;
  assign sf_sclk = half;

  assign buf_addr  = bidx[BUF_AW-1:0];
  assign buf_re    = step && tgt == P_TX;
  assign buf_we    = ph == P_RX && half && cnt == 6'd1;
  assign buf_wdata = rsh;

  always_comb
    case (reg_sel)
      3'd0:    reg_rdata = {busy, fin, 29'h0, upd};
      3'd1:    reg_rdata = c1;
      3'd2:    reg_rdata = c2;
      3'd3:    reg_rdata = c3;
      3'd4:    reg_rdata = adr;
      default: reg_rdata = '0;
    endcase
endmodule

module sflash_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sclk,
  input logic [3:0] oe,
  input logic       we,
  input logic       busy,
  input logic       fin,
  input logic       upd
);
  a_r9_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);
  a_r9_sclk_one_high: assert property (@(posedge clk) disable iff (!rst_n) sclk |=> !sclk);
  a_r12_oe_idle_off: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> oe == 4'b0000);
  a_r12_oe_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (oe == 4'b0000) || (oe == 4'b0001) || (oe == 4'b0011) || (oe == 4'b1111));
  a_r8_write_in_txn: assert property (@(posedge clk) disable iff (!rst_n) we |-> !cs_n);
  a_r10_fin_excl_busy: assert property (@(posedge clk) disable iff (!rst_n) !(busy && fin));
  a_r10_fin_after_busy: assert property (@(posedge clk) disable iff (!rst_n) $rose(fin) |-> $past(busy));
  a_r10_cs_release: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> cs_n);
  a_r10_upd_with_fin: assert property (@(posedge clk) disable iff (!rst_n) upd |-> fin);
endmodule

bind sflash_seq sflash_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(sf_cs_n), .sclk(sf_sclk), .oe(sf_oe),
  .we(buf_we), .busy(busy), .fin(fin), .upd(upd)
);

// File: tb/sflash_seq_tb.sv
module sflash_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sf_cs_n, sf_sclk;
  logic [3:0]  sf_dout, sf_oe;
  logic [3:0]  sf_din = 4'h0;
  logic [8:0]  buf_addr;
  logic        buf_re, buf_we;
  logic [7:0]  buf_wdata, buf_rdata;

  always #5 clk = ~clk;

  sflash_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sf_cs_n(sf_cs_n), .sf_sclk(sf_sclk), .sf_dout(sf_dout),
    .sf_oe(sf_oe), .sf_din(sf_din), .buf_addr(buf_addr), .buf_re(buf_re), .buf_we(buf_we),
    .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
  );

  logic [7:0]  mem [512];
  logic [7:0]  rx_bytes [512];
  logic [3:0]  rx_st [4096];
  logic [15:0] exp_q [$];
  int errors = 0, checks = 0, rises = 0, cs_low = 0;
  logic sclk_q = 1'b0;

  assign buf_rdata = mem[buf_addr];
  always @(posedge clk) if (buf_we) mem[buf_addr] <= buf_wdata;

  // monitor: compare lanes at each serial clock rise, drive receive lanes
  always @(negedge clk) begin
    logic [15:0] e;
    if (sf_sclk && !sclk_q) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3 extra serial clock: got oe=%b out=%b expected none", sf_oe, sf_dout);
      end else begin
        e = exp_q.pop_front();
        if ({sf_oe, sf_dout} !== e[7:0]) begin
          errors++;
          $display("FAIL R%0d lanes at clock %0d: got %h expected %h", e[15:8], rises, {sf_oe, sf_dout}, e[7:0]);
        end
      end
      rises++;
    end
    sclk_q = sf_sclk;
    if (!sf_cs_n) cs_low++;
    sf_din = rx_st[rises % 4096];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk); reg_sel = s; #1; d = reg_rdata;
  endtask

  task automatic push_byte(input int tag, input logic [7:0] b, input int m);
    for (int k = 0; k < (8 >> m); k++)
      case (m)
        0: exp_q.push_back({8'(tag), 4'b0001, 3'b000, b[7-k]});
        1: exp_q.push_back({8'(tag), 4'b0011, 2'b00, b[7-2*k], b[6-2*k]});
        default: exp_q.push_back({8'(tag), 4'b1111, b[7-4*k -: 4]});
      endcase
  endtask

  task automatic push_rx(input logic [7:0] r, input int m);
    for (int k = 0; k < (8 >> m); k++) begin
      case (m)
        0: rx_st[exp_q.size()] = {2'b00, r[7-k], 1'b0};
        1: rx_st[exp_q.size()] = {2'b00, r[7-2*k], r[6-2*k]};
        default: rx_st[exp_q.size()] = r[7-4*k -: 4];
      endcase
      exp_q.push_back({8'd8, 8'h00});
    end
  endtask

  function automatic logic [31:0] f_cmd(int m, logic [7:0] op);
    return 32'(1) << 30 | 32'(m) << 28 | 32'(op) << 20;
  endfunction
  function automatic logic [31:0] f_addr(int m, int nb);
    return 32'(1) << 19 | 32'(m) << 17 | 32'(nb - 1) << 15;
  endfunction
  function automatic logic [31:0] f_tx(int m, int n);
    return 32'(1) << 14 | 32'(m) << 10 | 32'(n);
  endfunction
  function automatic logic [31:0] f_dummy(int m, int n);
    return 32'(1) << 31 | 32'(m) << 29 | 32'(n) << 23;
  endfunction
  function automatic logic [31:0] f_rx(int m, int n);
    return 32'(1) << 31 | 32'(m) << 27 | 32'(n) << 16;
  endfunction

  task automatic run(input string name, input logic [31:0] r1, input logic [31:0] r2,
                     input logic [31:0] r3, input logic [31:0] a, input bit poke);
    int nclk, txn, rxn, guard;
    logic [31:0] v;
    exp_q.delete();
    for (int k = 0; k < 4096; k++) rx_st[k] = 4'h0;
    if (r1[30]) push_byte(4, r1[27:20], int'(r1[29:28]));
    if (r1[19]) for (int j = int'(r1[16:15]); j >= 0; j--) push_byte(5, a[8*j +: 8], int'(r1[18:17]));
    if (r2[31]) for (int k = 0; k < int'(r2[28:23]); k++) exp_q.push_back({8'd6, 8'h00});
    txn = (int'(r1[9:0]) > 512) ? 512 : int'(r1[9:0]);
    rxn = (int'(r3[25:16]) > 512) ? 512 : int'(r3[25:16]);
    if (!r1[14]) txn = 0;
    if (!r3[31]) rxn = 0;
    for (int k = 0; k < txn; k++) push_byte(7, mem[k], int'(r1[11:10]));
    for (int k = 0; k < rxn; k++) push_rx(rx_bytes[k], int'(r3[28:27]));
    nclk = exp_q.size();
    for (int k = 0; k < 4; k++) wr(3'(k), 32'h0);
    wr(3'd1, r1); wr(3'd2, r2); wr(3'd3, r3); wr(3'd4, a);
    rises = 0; cs_low = 0;
    wr(3'd0, 32'h8000_0000);
    if (poke) begin
      rd(3'd0, v);
      chk({"R2 busy set, finish cleared ", name}, {30'h0, v[31:30]}, 32'h2);
      wr(3'd0, 32'h8000_0000);
    end
    guard = 0;
    do begin rd(3'd0, v); guard++; end while (!v[30] && guard < 20000);
    chk({"R10 finish set, busy clear ", name}, {30'h0, v[31:30]}, 32'h1);
    chk({"R10 updated only after receive ", name}, {31'h0, v[0]}, {31'h0, rxn != 0});
    chk({"R3 all expected clocks seen ", name}, exp_q.size(), 0);
    chk({"R9 chip select low cycles ", name}, cs_low, 2 * nclk + 1);
    for (int k = 0; k < rxn; k++)
      chk({"R8 received byte in buffer ", name}, {24'h0, mem[k]}, {24'h0, rx_bytes[k]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int k = 0; k < 512; k++) mem[k] = 8'(k * 37 + 5);
    repeat (3) @(negedge clk);
    chk("R1 reset chip select high", {31'h0, sf_cs_n}, 1);
    chk("R1 reset sclk low", {31'h0, sf_sclk}, 0);
    chk("R12 reset lanes released", {28'h0, sf_oe}, 0);
    rst_n = 1'b1;
    for (int k = 0; k < 5; k++) begin rd(3'(k), v); chk("R1 register reset value", v, 0); end
    wr(3'd1, 32'h5A5A_C3C3); rd(3'd1, v); chk("R1 readback reg1", v, 32'h5A5A_C3C3);
    wr(3'd4, 32'hDEAD_BEEF); rd(3'd4, v); chk("R1 readback reg4", v, 32'hDEAD_BEEF);
    wr(3'd2, 32'h1234_5678); rd(3'd2, v); chk("R1 readback reg2", v, 32'h1234_5678);

    run("R4 opcode single", f_cmd(0, 8'h9F), 0, 0, 0, 0);
    for (int k = 0; k < 512; k++) rx_bytes[k] = 8'(k * 11 + 200);
    run("R5 R8 dual opcode, 3-byte address, single read", f_cmd(1, 8'h3B) | f_addr(0, 3), 0,
        f_rx(0, 4), 32'h77A1_B2C3, 0);
    for (int k = 0; k < 512; k++) rx_bytes[k] = 8'(k * 29 + 7);
    run("R6 R8 quad address, dummy, quad read", f_cmd(0, 8'hEB) | f_addr(2, 4), f_dummy(2, 8),
        f_rx(2, 5), 32'h1234_5678, 0);
    run("R7 quad opcode, dual transmit", f_cmd(2, 8'h32) | f_tx(1, 3), 0, 0, 0, 0);
    for (int k = 0; k < 512; k++) mem[k] = 8'(k * 13 + 1);
    run("R7 transmit count clamped", f_cmd(0, 8'h02) | f_addr(0, 3) | f_tx(2, 600), 0, 0,
        32'h0001_0203, 0);
    for (int k = 0; k < 512; k++) rx_bytes[k] = 8'(k * 5 + 90);
    run("R3 transmit then dual receive", f_tx(0, 2), 0, f_rx(1, 3), 0, 0);
    run("R10 no phases", 0, 0, 0, 0, 0);
    run("R3 zero-count dummy and receive skipped", f_cmd(0, 8'h05), 32'h8000_0000,
        32'h8000_0000, 0, 0);
    run("R11 restart ignored", f_cmd(0, 8'hA5) | f_addr(1, 2), 0, 0, 32'h0000_BEAD, 1);
    run("R2 finish cleared on new start", f_cmd(1, 8'h6C), 0, 0, 0, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule